// File: doc/BRIEF.md
# Global-History Correlating Branch Predictor

This block predicts the direction of conditional branches from two sources at once: the outcomes of the most recent branches anywhere in the program, and a slice of the branch's own address. A global shift register keeps the last `HIST_BITS` resolved outcomes. Those bits are joined with `ADDR_BITS` bits taken from the program counter to pick one saturating counter from a table. The top bit of that counter is the prediction. Because the address slice is only part of the PC, two branches whose selected bits are equal share the same counters.

The block has two ports. The lookup port is combinational: a PC goes in, and a taken/not-taken guess comes out in the same cycle. The update port takes a resolved branch PC and its real outcome. On the clock edge it trains the counter that the pre-update history and that PC select, and it shifts the outcome into the history. Each 2-bit counter is a four-state machine: STRONG_NT, WEAK_NT, WEAK_T and STRONG_T. A taken outcome moves the counter one state toward STRONG_T and a not-taken outcome moves it one state toward STRONG_NT. The end states saturate on themselves. The counter crosses between the WEAK_NT and WEAK_T states, so a strongly biased entry needs two wrong outcomes in a row before its prediction flips.

With the default parameters (2 history bits, 8 address bits, 2-bit counters) the table holds 1024 counters. Setting `HIST_BITS` to 0 removes the history register, which leaves a plain per-address counter table.

Top module: `corr_branch_predictor`

## Requirements
- R1: After reset the history reads all not-taken (0). Every counter holds 01 (WEAK_NT), so every lookup predicts not-taken until an update trains an entry.
- R2: Counter encoding: 00 is STRONG_NT, 01 is WEAK_NT, 10 is WEAK_T and 11 is STRONG_T. `lk_pred` is the most significant bit of the selected counter, where 1 means taken.
- R3: The table index is `{pc[ADDR_LSB +: ADDR_BITS], history}`, with the history in the low bits. The default `ADDR_LSB` is 2. PCs that agree in those address bits alias onto the same counters.
- R4: On an update, the outcome (1 = taken) enters history bit 0 and every older bit moves up one place. The oldest bit is dropped.
- R5: An update changes only the one counter selected by `up_pc` and by the history as it stood before that same update.
- R6: A taken outcome raises the counter by one and saturates at 11. A not-taken outcome lowers it by one and saturates at 00. From a strong state, the prediction flips only after two successive opposite outcomes.
- R7: When a lookup and an update happen in the same cycle, the lookup returns the prediction from the state before the update.
- R8: While `up_valid` is low, neither the history nor any counter changes, whatever `up_pc` and `up_taken` carry.
- R9: With `HIST_BITS` = 0 the index is the address bits alone, and the block behaves as a per-address 2-bit counter table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | PC_W | PC of the branch being looked up |
| lk_pred | output | 1 | Predicted direction, 1 = taken |
| up_valid | input | 1 | A resolved branch is presented this cycle |
| up_pc | input | PC_W | PC of the resolved branch |
| up_taken | input | 1 | Resolved outcome, 1 = taken |

## Verification
The bench tests the predictor against a behavioural model in several ways:
- **Saturation and hysteresis.** A single branch gets a run of taken outcomes followed by a run of not-taken outcomes. This shows whether the counter saturates and whether its prediction lags by two outcomes.
- **History in the index.** A branch with a strict taken/not-taken alternation can only be predicted well if the history bits really reach the index, which separates this block from a history-free table.
- **Aliasing.** PCs that differ only above the address slice, or only inside it, are looked up while a neighbouring branch is trained. This shows which counters are shared and which stay apart.
- **Random mix and the reduced variant.** Idle cycles with noisy update fields, and a long pseudo-random mix of a few branches, are run on the default block and on the zero-history variant together. Each variant is compared against its own model on every cycle.

// File: rtl/bp_pkg.sv
package bp_pkg;

    // Four-state direction counter used when counters are two bits wide
    typedef enum logic [1:0] {
        CTR_STRONG_NT = 2'b00,
        CTR_WEAK_NT   = 2'b01,
        CTR_WEAK_T    = 2'b10,
        CTR_STRONG_T  = 2'b11
    } ctr2_e;

    // Width of a vector that must exist even when its count is zero
    function automatic int unsigned nz_width(input int unsigned w);
        return (w == 0) ? 1 : w;
    endfunction

endpackage

// File: rtl/bp_ctr_step.sv
module bp_ctr_step
    import bp_pkg::*;
#(
    parameter int unsigned CTR_BITS = 2
) (
    input  logic [CTR_BITS-1:0] cur,
    input  logic                taken,
    output logic [CTR_BITS-1:0] nxt
);

    localparam logic [CTR_BITS-1:0] CTR_MAX = {CTR_BITS{1'b1}};
    localparam logic [CTR_BITS-1:0] CTR_MIN = '0;

    generate
        if (CTR_BITS == 2) begin : g_fsm
            ctr2_e state, next_state;
            assign state = ctr2_e'(cur);

            always_comb begin
                next_state = state;
                unique case (state)
                    CTR_STRONG_NT: next_state = taken ? CTR_WEAK_NT  : CTR_STRONG_NT;
                    CTR_WEAK_NT:   next_state = taken ? CTR_WEAK_T   : CTR_STRONG_NT;
                    CTR_WEAK_T:    next_state = taken ? CTR_STRONG_T : CTR_WEAK_NT;
                    CTR_STRONG_T:  next_state = taken ? CTR_STRONG_T : CTR_WEAK_T;
                    default:       next_state = CTR_WEAK_NT;
                endcase
            end

            assign nxt = next_state;
        end else begin : g_sat
            always_comb begin
                if (taken) nxt = (cur == CTR_MAX) ? cur : cur + 1'b1;
                else       nxt = (cur == CTR_MIN) ? cur : cur - 1'b1;
            end
        end
    endgenerate

    // R6: a counter never moves more than one step per outcome
    always_comb begin
        if (!$isunknown({cur, taken, nxt})) begin
            a_r6_one_step: assert ((int'(nxt) == int'(cur)) ||
                                   (int'(nxt) == int'(cur) + 1) ||
                                   (int'(nxt) + 1 == int'(cur)));
        end
    end

endmodule

// File: rtl/bp_history.sv
module bp_history
    import bp_pkg::*;
#(
    parameter int unsigned HIST_BITS = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           shift_en,
    input  logic                           shift_in,
    output logic [nz_width(HIST_BITS)-1:0] hist
);

    generate
        if (HIST_BITS == 0) begin : g_none
            assign hist = 1'b0;
        end else begin : g_reg
            logic [HIST_BITS-1:0] hist_q;

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    hist_q <= '0;
                end else if (shift_en) begin
                    if (HIST_BITS == 1) hist_q <= shift_in;
                    else                hist_q <= {hist_q[HIST_BITS-2:0], shift_in};
                end
            end

            assign hist = hist_q;

            // R4: the newest outcome lands in bit 0
            a_r4_newest_low: assert property (@(posedge clk) disable iff (!rst_n)
                shift_en |=> hist_q[0] == $past(shift_in));

            // R8: history holds when no update is presented
            a_r8_hist_hold: assert property (@(posedge clk) disable iff (!rst_n)
                !shift_en |=> $stable(hist_q));

            if (HIST_BITS > 1) begin : g_age
                // R4: older outcomes move up one place
                a_r4_age_up: assert property (@(posedge clk) disable iff (!rst_n)
                    shift_en |=> hist_q[HIST_BITS-1:1] == $past(hist_q[HIST_BITS-2:0]));
            end
        end
    endgenerate

endmodule

// File: rtl/bp_index.sv
module bp_index
    import bp_pkg::*;
#(
    parameter int unsigned PC_W      = 32,
    parameter int unsigned ADDR_LSB  = 2,
    parameter int unsigned ADDR_BITS = 8,
    parameter int unsigned HIST_BITS = 2
) (
    input  logic [PC_W-1:0]                pc,
    input  logic [nz_width(HIST_BITS)-1:0] hist,
    output logic [ADDR_BITS+HIST_BITS-1:0] idx
);

    logic [ADDR_BITS-1:0] set_bits;
    assign set_bits = pc[ADDR_LSB +: ADDR_BITS];

    generate
        if (HIST_BITS == 0) begin : g_flat
            logic unused_hist;
            assign unused_hist = ^hist;
            assign idx = set_bits;
        end else begin : g_corr
            assign idx = {set_bits, hist};
        end
    endgenerate

endmodule

// File: rtl/bp_table.sv
module bp_table #(
    parameter int unsigned IDX_W    = 10,
    parameter int unsigned CTR_BITS = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [IDX_W-1:0]    rd_idx,
    output logic [CTR_BITS-1:0] rd_val,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    output logic [CTR_BITS-1:0] wr_cur,
    input  logic [CTR_BITS-1:0] wr_val
);

    localparam int unsigned DEPTH = 1 << IDX_W;
    // weakly not-taken: every bit set except the top one
    localparam logic [CTR_BITS-1:0] RST_VAL = {1'b0, {(CTR_BITS-1){1'b1}}};

    logic [CTR_BITS-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= RST_VAL;
        end else if (wr_en) begin
            cells[wr_idx] <= wr_val;
        end
    end

    assign rd_val = cells[rd_idx];
    assign wr_cur = cells[wr_idx];

    // R5: the trained entry holds the value computed for it
    a_r5_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> cells[$past(wr_idx)] == $past(wr_val));

endmodule

// File: rtl/corr_branch_predictor.sv
module corr_branch_predictor
    import bp_pkg::*;
#(
    parameter int unsigned PC_W      = 32,
    parameter int unsigned ADDR_LSB  = 2,
    parameter int unsigned ADDR_BITS = 8,
    parameter int unsigned HIST_BITS = 2,
    parameter int unsigned CTR_BITS  = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] lk_pc,
    output logic            lk_pred,
    input  logic            up_valid,
    input  logic [PC_W-1:0] up_pc,
    input  logic            up_taken
);

    localparam int unsigned IDX_W = ADDR_BITS + HIST_BITS;
    localparam int unsigned HW    = nz_width(HIST_BITS);

    logic [HW-1:0]       hist;
    logic [IDX_W-1:0]    lk_idx, up_idx;
    logic [CTR_BITS-1:0] lk_ctr, up_cur, up_nxt;

    bp_history #(.HIST_BITS(HIST_BITS)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (up_valid),
        .shift_in (up_taken),
        .hist     (hist)
    );

    bp_index #(.PC_W(PC_W), .ADDR_LSB(ADDR_LSB), .ADDR_BITS(ADDR_BITS),
               .HIST_BITS(HIST_BITS)) u_lk_idx (
        .pc   (lk_pc),
        .hist (hist),
        .idx  (lk_idx)
    );

    bp_index #(.PC_W(PC_W), .ADDR_LSB(ADDR_LSB), .ADDR_BITS(ADDR_BITS),
               .HIST_BITS(HIST_BITS)) u_up_idx (
        .pc   (up_pc),
        .hist (hist),
        .idx  (up_idx)
    );

    bp_table #(.IDX_W(IDX_W), .CTR_BITS(CTR_BITS)) u_table (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (lk_idx),
        .rd_val (lk_ctr),
        .wr_en  (up_valid),
        .wr_idx (up_idx),
        .wr_cur (up_cur),
        .wr_val (up_nxt)
    );

    bp_ctr_step #(.CTR_BITS(CTR_BITS)) u_step (
        .cur   (up_cur),
        .taken (up_taken),
        .nxt   (up_nxt)
    );

    assign lk_pred = lk_ctr[CTR_BITS-1];

    // R8: with no update last cycle and the same lookup PC, the answer is unchanged
    a_r8_pred_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(up_valid) && $stable(lk_pc)) |-> $stable(lk_pred));

endmodule

// File: tb/tb_corr_branch_predictor.sv
module tb_corr_branch_predictor;

    localparam int AB = 8;
    localparam int M  = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lk_pc = '0;
    logic        up_valid = 1'b0;
    logic [31:0] up_pc = '0;
    logic        up_taken = 1'b0;
    logic        pred_c, pred_f;

    always #4 clk = ~clk;

    corr_branch_predictor dut (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_pred(pred_c),
        .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken));

    corr_branch_predictor #(.HIST_BITS(0)) dut_flat (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_pred(pred_f),
        .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken));

    // behavioural model: one counter array and one history integer per variant
    int ctr_c [1 << (AB + M)];
    int ctr_f [1 << AB];
    int hist_c;
    int checks = 0, fails = 0;
    bit done = 0;
    logic [31:0] lfsr = 32'h1ACE_B00C;

    function automatic int idx_c(input logic [31:0] pc);
        return (((pc >> 2) & ((1 << AB) - 1)) << M) | (hist_c & ((1 << M) - 1));
    endfunction

    function automatic int idx_f(input logic [31:0] pc);
        return (pc >> 2) & ((1 << AB) - 1);
    endfunction

    function automatic int train(input int c, input bit t);
        if (t) return (c < 3) ? c + 1 : 3;
        return (c > 0) ? c - 1 : 0;
    endfunction

    task automatic model_reset();
        foreach (ctr_c[i]) ctr_c[i] = 1;
        foreach (ctr_f[i]) ctr_f[i] = 1;
        hist_c = 0;
    endtask

    task automatic check(input string tag, input string who, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s at %0t: actual %0d expected %0d", tag, who, $time, act, exp);
        end
    endtask

    // drive one cycle, compare the pre-edge predictions, then advance the model
    task automatic step(input string tag, input logic [31:0] lpc, input bit uv,
                        input logic [31:0] upc, input bit ut);
        int ec, ef;
        lk_pc = lpc; up_valid = uv; up_pc = upc; up_taken = ut;
        #1;
        ec = (ctr_c[idx_c(lpc)] >= 2) ? 1 : 0;
        ef = (ctr_f[idx_f(lpc)] >= 2) ? 1 : 0;
        check(tag, "corr", int'(pred_c), ec);
        check(tag, "flat", int'(pred_f), ef);
        @(posedge clk);
        if (uv) begin
            ctr_c[idx_c(upc)] = train(ctr_c[idx_c(upc)], ut);
            ctr_f[idx_f(upc)] = train(ctr_f[idx_f(upc)], ut);
            hist_c = ((hist_c << 1) | int'(ut)) & ((1 << M) - 1);
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: every entry weakly not-taken after reset
        for (int i = 0; i < 8; i++) step("R1", 32'h40 * i, 0, '0, 0);

        // R1 R2 R6: one taken flips a weak entry; saturation and two-step return
        step("R1 R6", 32'h100, 1, 32'h100, 1);
        for (int i = 0; i < 6; i++) step("R2 R6", 32'h100, 1, 32'h100, 1);
        for (int i = 0; i < 6; i++) step("R6", 32'h100, 1, 32'h100, 0);

        // R4 R5: strict alternation is learnt only through history
        for (int i = 0; i < 24; i++) step("R4 R5", 32'h200, 1, 32'h200, i[0]);

        // R3: aliasing above the address slice, separation inside it
        for (int i = 0; i < 6; i++) begin
            step("R3", 32'h40 + 32'h400, 1, 32'h40, 1);
            step("R3", 32'h44, 1, 32'h40, 1);
        end

        // R7: lookup of the very entry being trained sees the old value
        for (int i = 0; i < 8; i++) step("R7", 32'h300, 1, 32'h300, ~i[1]);

        // R8: noisy update fields while invalid change nothing
        for (int i = 0; i < 8; i++) step("R8", 32'h300, 0, 32'h300, 1);
        for (int i = 0; i < 8; i++) step("R8", 32'h100 + 32'h4 * i, 0, 32'h200, i[0]);

        // R2 R9: pseudo-random mix over a handful of branches, both variants
        for (int i = 0; i < 3000; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            step("R2 R9", {26'h0, lfsr[4:2], 3'b000} | 32'h1000 * lfsr[7],
                 lfsr[8] | lfsr[9],
                 {26'h0, lfsr[12:10], 3'b000} | 32'h1000 * lfsr[13],
                 lfsr[14] ^ (lfsr[12] & lfsr[15]));
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule